// File: doc/BRIEF.md
# Fused Multiply-Add NaN Operand Selector

This block decides which operand's NaN a fused multiply-add `(a*b)+c` returns when at least one of its inputs is a NaN. It also decides when the invalid-operation case of an infinity multiplied by a zero must produce the default NaN instead. Each operand arrives already classified as a 2-bit code. A product-operand flag marks the infinity-times-zero situation. A polarity input tells whether the signaling bit of a NaN is set or clear. A 2-bit policy input picks one of four propagation conventions.

The block is purely combinational. It returns a 2-bit choice (a, b, c or default NaN) in the same cycle as its inputs, together with an invalid flag. The surrounding datapath classifies the operands, quietens the chosen NaN and ORs in the invalid condition that signaling inputs cause. This block raises invalid only for the infinity-times-zero path.

Top module: `fma_nan_select`

## Requirements
- R1: Class codes are 0 = not a NaN, 1 = quiet NaN, 2 = signaling NaN; code 3 behaves exactly as code 0. The choice output `pick` encodes 0 = a, 1 = b, 2 = c, 3 = default NaN.
- R2: Policy 0 with `prod_inf_zero` = 1 and c quiet gives `pick` = 3 and `invalid` = 1.
- R3: Policy 0 with `prod_inf_zero` = 1 and c not quiet leaves `invalid` at 0 and uses the policy-0 ordering.
- R4: Policy 0 ordering is the first of: c signaling, a signaling, b signaling, c quiet, a quiet. If none of these holds, the choice is b.
- R5: Policy 1 with `sig_bit_high` = 1 and `prod_inf_zero` = 1 gives `pick` = 3 and `invalid` = 1, whatever the classes are.
- R6: Policy 1 with `sig_bit_high` = 1 and no infinity-times-zero takes the first of: a, b, c signaling, then a, b quiet. Otherwise it chooses c.
- R7: Policy 1 with `sig_bit_high` = 0 and `prod_inf_zero` = 1 gives `pick` = 2 and `invalid` = 1.
- R8: Policy 1 with `sig_bit_high` = 0 and no infinity-times-zero uses the policy-0 ordering.
- R9: Policy 2 with `prod_inf_zero` = 1 gives `pick` = 2 and `invalid` = 1. Otherwise it chooses a if a is any NaN, else c if c is any NaN, else b.
- R10: Policy 3 chooses a if a is any NaN, else b if b is any NaN, else c. `prod_inf_zero` has no effect on either output.
- R11: `invalid` is 1 only when `prod_inf_zero` = 1. Signaling inputs alone never set it, and `pick` = 3 always comes with `invalid` = 1.
- R12: The outputs follow the inputs with no clock, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_cls | input | 2 | Class code of multiplicand a |
| b_cls | input | 2 | Class code of multiplier b |
| c_cls | input | 2 | Class code of addend c |
| prod_inf_zero | input | 1 | One product operand is infinity and the other is zero |
| sig_bit_high | input | 1 | 1 when a set signaling bit marks a signaling NaN |
| policy | input | 2 | Propagation convention select, 0 to 3 |
| pick | output | 2 | Chosen result source: 0 a, 1 b, 2 c, 3 default NaN |
| invalid | output | 1 | Invalid raised by the infinity-times-zero path |

## Verification
Two cases are the hardest to reach from the ports. The first is the infinity-times-zero flag combined with an addend that is not quiet, where policy 0 must fall back to its normal ordering. The second is the reserved class code 3 in any position. Both are easy to miss with sparse stimulus. The bench therefore sweeps every combination of the three class codes, the flag, the polarity and the policy. It compares each one against a behavioural model, so every ordering tie and every override is visited.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

   localparam int NUM_OPS     = 3;
   localparam int NUM_SCHEMES = 4;
   localparam int RANK_DEPTH  = 5;

   typedef enum logic [1:0] {
      CLS_NUM  = 2'd0,
      CLS_QNAN = 2'd1,
      CLS_SNAN = 2'd2,
      CLS_RSVD = 2'd3
   } nan_cls_e;

   typedef enum logic [1:0] {
      PICK_A    = 2'd0,
      PICK_B    = 2'd1,
      PICK_C    = 2'd2,
      PICK_DFLT = 2'd3
   } pick_e;

   typedef enum int {
      K_NONE  = 0,
      K_SIG   = 1,
      K_QUIET = 2,
      K_ANY   = 3
   } rank_kind_e;

   // Ranking schemes:
   // 0: c,a,b signaling then c,a quiet, fallback b
   // 1: a,b,c signaling then a,b quiet, fallback c
   // 2: a any NaN then c any NaN, fallback b
   // 3: a any NaN then b any NaN, fallback c
   function automatic int rank_op(input int scheme, input int idx);
      int ops0 [RANK_DEPTH] = '{2, 0, 1, 2, 0};
      int ops1 [RANK_DEPTH] = '{0, 1, 2, 0, 1};
      int ops2 [RANK_DEPTH] = '{0, 2, 0, 0, 0};
      int ops3 [RANK_DEPTH] = '{0, 1, 0, 0, 0};
      case (scheme)
         0:       return ops0[idx];
         1:       return ops1[idx];
         2:       return ops2[idx];
         default: return ops3[idx];
      endcase
   endfunction

   function automatic rank_kind_e rank_kind(input int scheme, input int idx);
      if (scheme < 2) return (idx < 3) ? K_SIG : K_QUIET;
      return (idx < 2) ? K_ANY : K_NONE;
   endfunction

   function automatic int rank_fallback(input int scheme);
      return (scheme == 0 || scheme == 2) ? 1 : 2;
   endfunction

endpackage

// File: rtl/fma_nan_classdec.sv
module fma_nan_classdec
   import fma_nan_pkg::*;
#(
   parameter int N_OPS = NUM_OPS,
   parameter int CLS_W = 2
)(
   input  logic [N_OPS-1:0][CLS_W-1:0] cls,
   output logic [N_OPS-1:0]            is_q,
   output logic [N_OPS-1:0]            is_s
);

   if (CLS_W != 2) begin : g_bad_w
      $error("fma_nan_classdec: CLS_W must be 2");
   end

   for (genvar i = 0; i < N_OPS; i++) begin : g_op
      assign is_q[i] = (cls[i] == CLS_W'(CLS_QNAN));
      assign is_s[i] = (cls[i] == CLS_W'(CLS_SNAN));

      // R1
      always_comb begin
         q_s_exclusive_chk: assert (!(is_q[i] && is_s[i]));
      end
   end

endmodule

// File: rtl/fma_nan_rank.sv
module fma_nan_rank
   import fma_nan_pkg::*;
#(
   parameter int SCHEME = 0,
   parameter int N_OPS  = NUM_OPS
)(
   input  logic [N_OPS-1:0] is_q,
   input  logic [N_OPS-1:0] is_s,
   output logic [1:0]       pick
);

   localparam int DEPTH = RANK_DEPTH;
   localparam int FB_OP = rank_fallback(SCHEME);

   if (SCHEME < 0 || SCHEME >= NUM_SCHEMES) begin : g_bad_scheme
      $error("fma_nan_rank: SCHEME out of range");
   end

   logic [DEPTH-1:0] hit;
   logic [N_OPS-1:0] is_nan;
   logic             unused_bits;

   assign is_nan      = is_q | is_s;
   assign unused_bits = ^{is_q, is_s};

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam int         OPI  = rank_op(SCHEME, i);
      localparam rank_kind_e KIND = rank_kind(SCHEME, i);
      if (KIND == K_SIG) begin : g_sig
         assign hit[i] = is_s[OPI];
      end else if (KIND == K_QUIET) begin : g_quiet
         assign hit[i] = is_q[OPI];
      end else if (KIND == K_ANY) begin : g_any
         assign hit[i] = is_nan[OPI];
      end else begin : g_none
         assign hit[i] = 1'b0;
      end
   end

   always_comb begin
      pick = 2'(FB_OP);
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit[i]) pick = 2'(rank_op(SCHEME, i));
      end
   end

   // R4 R6 R9 R10: a NaN among the inputs is never passed over for a non-NaN
   always_comb begin
      if (pick != 2'd3 && |is_nan) begin
         nan_chosen_chk: assert (is_nan[pick]);
      end
   end

   if (SCHEME < 2) begin : g_sig_chk
      // R4 R6: signaling inputs outrank quiet ones
      always_comb begin
         if (pick != 2'd3 && |is_s) begin
            sig_first_chk: assert (is_s[pick]);
         end
      end
   end

endmodule

// File: rtl/fma_nan_infzero.sv
module fma_nan_infzero
   import fma_nan_pkg::*;
#(
   parameter int POL_W = 2
)(
   input  logic [POL_W-1:0] policy,
   input  logic             sig_bit_high,
   input  logic             prod_inf_zero,
   input  logic             c_quiet,
   output logic             take,
   output logic [1:0]       ovr_pick
);

   if (POL_W != 2) begin : g_bad_pol
      $error("fma_nan_infzero: POL_W must be 2");
   end

   always_comb begin
      take     = 1'b0;
      ovr_pick = PICK_C;
      case (policy)
         2'd0: begin
            take     = prod_inf_zero && c_quiet;
            ovr_pick = PICK_DFLT;
         end
         2'd1: begin
            take     = prod_inf_zero;
            ovr_pick = sig_bit_high ? PICK_DFLT : PICK_C;
         end
         2'd2: begin
            take     = prod_inf_zero;
            ovr_pick = PICK_C;
         end
         default: begin
            take     = 1'b0;
            ovr_pick = PICK_C;
         end
      endcase
   end

   // R10
   always_comb begin
      pol3_no_take_chk: assert (!(policy == 2'd3 && take));
   end

   // R11
   always_comb begin
      take_needs_flag_chk: assert (!take || prod_inf_zero);
   end

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
   import fma_nan_pkg::*;
#(
   parameter int CLS_W = 2,
   parameter int POL_W = 2
)(
   input  logic [CLS_W-1:0] a_cls,
   input  logic [CLS_W-1:0] b_cls,
   input  logic [CLS_W-1:0] c_cls,
   input  logic             prod_inf_zero,
   input  logic             sig_bit_high,
   input  logic [POL_W-1:0] policy,
   output logic [1:0]       pick,
   output logic             invalid
);

   localparam int SCH_W = $clog2(NUM_SCHEMES);

   if (CLS_W != 2 || POL_W != 2) begin : g_bad_params
      $error("fma_nan_select: CLS_W and POL_W must both be 2");
   end

   logic [NUM_OPS-1:0][CLS_W-1:0] cls_all;
   logic [NUM_OPS-1:0]            is_q;
   logic [NUM_OPS-1:0]            is_s;
   logic [NUM_SCHEMES-1:0][1:0]   rank_pick;
   logic [SCH_W-1:0]              scheme_sel;
   logic                          ovr_take;
   logic [1:0]                    ovr_pick;

   assign cls_all = {c_cls, b_cls, a_cls};

   fma_nan_classdec #(
      .N_OPS (NUM_OPS),
      .CLS_W (CLS_W)
   ) u_dec (
      .cls  (cls_all),
      .is_q (is_q),
      .is_s (is_s)
   );

   for (genvar s = 0; s < NUM_SCHEMES; s++) begin : g_rank
      fma_nan_rank #(
         .SCHEME (s),
         .N_OPS  (NUM_OPS)
      ) u_rank (
         .is_q (is_q),
         .is_s (is_s),
         .pick (rank_pick[s])
      );
   end

   fma_nan_infzero #(
      .POL_W (POL_W)
   ) u_iz (
      .policy        (policy),
      .sig_bit_high  (sig_bit_high),
      .prod_inf_zero (prod_inf_zero),
      .c_quiet       (is_q[2]),
      .take          (ovr_take),
      .ovr_pick      (ovr_pick)
   );

   always_comb begin
      case (policy)
         2'd0:    scheme_sel = SCH_W'(0);
         2'd1:    scheme_sel = sig_bit_high ? SCH_W'(1) : SCH_W'(0);
         2'd2:    scheme_sel = SCH_W'(2);
         default: scheme_sel = SCH_W'(3);
      endcase
   end

   assign pick    = ovr_take ? ovr_pick : rank_pick[scheme_sel];
   assign invalid = ovr_take;

   // R11
   always_comb begin
      dflt_has_invalid_chk: assert (pick != 2'd3 || invalid);
   end

   // R11
   always_comb begin
      no_flag_no_invalid_chk: assert (prod_inf_zero || !invalid);
   end

   // R7 R9
   always_comb begin
      if (invalid && policy[1] != policy[0] && !sig_bit_high) begin
         iz_addend_chk: assert (pick == 2'd2);
      end
   end

endmodule

// File: tb/fma_nan_select_tb.sv
`timescale 1ns/1ps
module fma_nan_select_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] a_cls, b_cls, c_cls, policy;
   logic       prod_inf_zero, sig_bit_high;
   logic [1:0] pick;
   logic       invalid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   fma_nan_select u_dut (
      .a_cls         (a_cls),
      .b_cls         (b_cls),
      .c_cls         (c_cls),
      .prod_inf_zero (prod_inf_zero),
      .sig_bit_high  (sig_bit_high),
      .policy        (policy),
      .pick          (pick),
      .invalid       (invalid)
   );

   // Behavioural reference built from the requirement list
   function automatic void model(input int pol, input int sbh, input int iz,
                                 input int ca, input int cb, input int cc,
                                 output int sel, output int inv, output string tag);
      bit qa = (ca == 1), sa = (ca == 2);
      bit qb = (cb == 1), sb = (cb == 2);
      bit qc = (cc == 1), sc = (cc == 2);
      inv = 0;
      if (pol == 0) begin
         if (iz != 0 && qc) begin sel = 3; inv = 1; tag = "R2"; end
         else begin
            tag = (iz != 0) ? "R3" : "R4";
            if (sc) sel = 2; else if (sa) sel = 0; else if (sb) sel = 1;
            else if (qc) sel = 2; else if (qa) sel = 0; else sel = 1;
         end
      end else if (pol == 1 && sbh != 0) begin
         if (iz != 0) begin sel = 3; inv = 1; tag = "R5"; end
         else begin
            tag = "R6";
            if (sa) sel = 0; else if (sb) sel = 1; else if (sc) sel = 2;
            else if (qa) sel = 0; else if (qb) sel = 1; else sel = 2;
         end
      end else if (pol == 1) begin
         if (iz != 0) begin sel = 2; inv = 1; tag = "R7"; end
         else begin
            tag = "R8";
            if (sc) sel = 2; else if (sa) sel = 0; else if (sb) sel = 1;
            else if (qc) sel = 2; else if (qa) sel = 0; else sel = 1;
         end
      end else if (pol == 2) begin
         tag = "R9";
         if (iz != 0) begin sel = 2; inv = 1; end
         else if (qa || sa) sel = 0; else if (qc || sc) sel = 2; else sel = 1;
      end else begin
         tag = "R10";
         if (qa || sa) sel = 0; else if (qb || sb) sel = 1; else sel = 2;
      end
      if (iz == 0 && (sa || sb || sc)) tag = {tag, ",R11"};
      if (ca == 3 || cb == 3 || cc == 3) tag = {tag, ",R1"};
   endfunction

   task automatic check(input string tag, input int exp_sel, input int exp_inv);
      n_tests++;
      if (int'(pick) != exp_sel || int'(invalid) != exp_inv) begin
         n_fail++;
         $display("FAIL %s pol=%0d sbh=%0d iz=%0d cls=%0d/%0d/%0d: pick=%0d invalid=%0d expected pick=%0d invalid=%0d",
                  tag, policy, sig_bit_high, prod_inf_zero, a_cls, b_cls, c_cls,
                  pick, invalid, exp_sel, exp_inv);
      end
   endtask

   task automatic apply(input int pol, input int sbh, input int iz,
                        input int ca, input int cb, input int cc);
      policy        = 2'(pol);
      sig_bit_high  = 1'(sbh);
      prod_inf_zero = 1'(iz);
      a_cls         = 2'(ca);
      b_cls         = 2'(cb);
      c_cls         = 2'(cc);
   endtask

   initial begin
      int es, ei;
      string tg;
      rst_n = 1'b0;
      apply(0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1: all operands non-NaN under policy 0 select b, no invalid
      check("R1 idle", 1, 0);

      // R12: outputs follow an input change with no clock edge in between
      @(negedge clk);
      apply(3, 0, 0, 0, 0, 2);
      #1;
      check("R12 pol3 c sig", 2, 0);
      apply(3, 0, 0, 1, 0, 2);
      #1;
      check("R12 pol3 a quiet", 0, 0);
      apply(0, 0, 1, 0, 0, 1);
      #1;
      check("R12 R2 override", 3, 1);

      // Exhaustive sweep against the model, one vector per clock
      for (int pol = 0; pol < 4; pol++) begin
         for (int sbh = 0; sbh < 2; sbh++) begin
            for (int iz = 0; iz < 2; iz++) begin
               for (int ca = 0; ca < 4; ca++) begin
                  for (int cb = 0; cb < 4; cb++) begin
                     for (int cc = 0; cc < 4; cc++) begin
                        @(negedge clk);
                        apply(pol, sbh, iz, ca, cb, cc);
                        #2;
                        model(pol, sbh, iz, ca, cb, cc, es, ei, tg);
                        check(tg, es, ei);
                     end
                  end
               end
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule